// File: doc/BRIEF.md
# Audio Codec Control-Word Boot Sequencer

This block brings up an external stereo audio codec over a one-way, SPI-style control link. After a start pulse it sends a fixed set of ten configuration writes. Each write is one 16-bit control word that carries a register address and a register value. The word is shifted out MSB first while chip-select is held low. Nothing is read back from the codec.

Once the boot writes are finished, a host can change the sample rate. It pulses a request together with an 8-bit rate code. The block then rewrites only the sample-rate register. A request that arrives while the boot writes are still running is held, and it is served after the final activation write. Outside of these writes the link stays idle, so audio data can flow undisturbed.

Top module: `codec_cfg_seq`

## Requirements
- R1: After reset `cs_n_o` is high, `sclk_o`, `mosi_o`, `busy_o` and `done_o` are low, and no frame is sent until `start_i` or a valid rate request arrives.
- R2: Every control word is 16 bits, with the register address in bits 15:9 and the register value in bits 8:0. It is sent MSB first. `sclk_o` idles low, the codec samples `mosi_o` on the rising edge, and `mosi_o` does not change while `sclk_o` is high.
- R3: A `start_i` pulse sends registers 0 to 9 in ascending order, with the values 0x017, 0x017, 0x0D8, 0x0D8, 0x011, 0x000, 0x000, 0x043, 0x081 and 0x001. Register 9 (interface activation) is always the last word.
- R4: `cs_n_o` stays low for exactly 16×CLK_DIV clock cycles per word, with 16 rising edges of `sclk_o`. Between two words it stays high for at least GAP_SCLK×CLK_DIV cycles.
- R5: A rate request with one of the codes 0x06, 0x2C, 0x20, 0x0C, 0x11, 0x00 or 0x0E sends exactly one word. That word has address 8 and value {1'b0, code}.
- R6: A rate request with any other code is ignored. No frame is sent and `busy_o` stays low.
- R7: A valid rate request made during the boot writes is held and sent right after the register 9 word. If several valid requests arrive before it is sent, the newest code is used and only one word goes out.
- R8: `busy_o` rises in the cycle after a job is accepted. It falls in the cycle in which `cs_n_o` rises after the job's last word, and `done_o` is high for exactly that one cycle.
- R9: A `start_i` pulse while `busy_o` is high is ignored, so the boot sequence is not restarted or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to begin the boot write sequence |
| rate_req_i | input | 1 | Pulse to request a sample-rate rewrite |
| rate_code_i | input | 8 | Rate-select code, sampled with `rate_req_i` |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data, MSB first |
| cs_n_o | output | 1 | Chip-select, active low for one word |
| busy_o | output | 1 | A boot or rate job is in progress |
| done_o | output | 1 | One-cycle pulse when a job completes |

## Verification
The bench checks the following corner cases:

- **Start during boot.** A start pulse is sent in the middle of the boot writes. A design that restarted would send more than ten boot words.
- **Requests during boot.** An invalid code and then two valid codes are requested before register 9 goes out. A design that served a request early would put a register 8 word between boot words. A design that queued every request would send two rate words. A design that latched the invalid code would write a wrong value.
- **Rate codes after boot.** All seven rate codes are tried one after another, followed by random bytes. A design that decoded the codes wrongly would send a frame for a byte it should ignore, or skip one it should write.
- **Frame shape.** Every frame is measured for its length, its clock edge count and the gap before it. A counter off by one shows up as a wrong length or too short a gap.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 7;
  localparam int VAL_W    = 9;
  localparam int NUM_REGS = 10;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] RATE_ADDR = ADDR_W'(8);

  typedef enum logic [1:0] {
    CTRL_IDLE = 2'd0,
    CTRL_BOOT = 2'd1,
    CTRL_RATE = 2'd2
  } ctrl_state_e;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SHIFT = 2'd1,
    SH_GAP   = 2'd2
  } sh_state_e;

  function automatic logic [VAL_W-1:0] boot_value(input logic [IDX_W-1:0] idx);
    case (idx)
      4'd0, 4'd1: boot_value = 9'h017;
      4'd2, 4'd3: boot_value = 9'h0D8;
      4'd4:       boot_value = 9'h011;
      4'd7:       boot_value = 9'h043;
      4'd8:       boot_value = 9'h081;
      4'd9:       boot_value = 9'h001;
      default:    boot_value = 9'h000;
    endcase
  endfunction

  function automatic logic rate_code_ok(input logic [7:0] code);
    case (code)
      8'h00, 8'h06, 8'h0C, 8'h0E, 8'h11, 8'h20, 8'h2C: rate_code_ok = 1'b1;
      default: rate_code_ok = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/codec_cfg_shifter.sv
module codec_cfg_shifter
  import codec_cfg_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int GAP_SCLK = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic              word_done_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              cs_n_o
);
  localparam int GAP_CYC = GAP_SCLK * CLK_DIV;
  localparam int MAX_CYC = (GAP_CYC > CLK_DIV) ? GAP_CYC : CLK_DIV;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(WORD_W);
  localparam int HALF    = CLK_DIV / 2;

  sh_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sh_q;

  logic period_end, last_bit;
  assign period_end = (cnt_q == CNT_W'(CLK_DIV - 1));
  assign last_bit   = (bit_q == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
    end else begin
      case (state_q)
        SH_IDLE: if (load_i) begin
          sh_q    <= word_i;
          cnt_q   <= '0;
          bit_q   <= '0;
          state_q <= SH_SHIFT;
        end
        SH_SHIFT: if (period_end) begin
          cnt_q <= '0;
          if (last_bit) begin
            state_q <= SH_GAP;
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        SH_GAP: if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
          cnt_q   <= '0;
          state_q <= SH_IDLE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == SH_IDLE);
  assign word_done_o = (state_q == SH_SHIFT) && period_end && last_bit;
  assign cs_n_o      = (state_q != SH_SHIFT);
  assign sclk_o      = (state_q == SH_SHIFT) && (cnt_q >= CNT_W'(HALF));
  assign mosi_o      = (state_q == SH_SHIFT) && sh_q[WORD_W-1];
endmodule

// File: rtl/codec_cfg_ctrl.sv
module codec_cfg_ctrl
  import codec_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rate_req_i,
  input  logic [7:0]        rate_code_i,
  input  logic              ready_i,
  input  logic              word_done_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o,
  output logic              busy_o,
  output logic              done_o
);
  ctrl_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic             issued_q;
  logic             pend_q;
  logic [7:0]       pend_code_q;
  logic             done_q;
  logic             req_ok;

  assign req_ok = rate_req_i && rate_code_ok(rate_code_i);

  always_comb begin
    load_o = 1'b0;
    word_o = '0;
    case (state_q)
      CTRL_BOOT: begin
        word_o = {ADDR_W'(idx_q), boot_value(idx_q)};
        load_o = ready_i && !issued_q;
      end
      CTRL_RATE: begin
        word_o = {RATE_ADDR, 1'b0, pend_code_q};
        load_o = ready_i && !issued_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= CTRL_IDLE;
      idx_q    <= '0;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        CTRL_IDLE: begin
          issued_q <= 1'b0;
          if (start_i) begin
            idx_q   <= '0;
            state_q <= CTRL_BOOT;
          end else if (pend_q) begin
            state_q <= CTRL_RATE;
          end
        end
        CTRL_BOOT: begin
          if (load_o) issued_q <= 1'b1;
          if (word_done_i) begin
            issued_q <= 1'b0;
            if (idx_q == IDX_W'(NUM_REGS - 1)) begin
              state_q <= CTRL_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        CTRL_RATE: begin
          if (load_o) issued_q <= 1'b1;
          if (word_done_i) begin
            issued_q <= 1'b0;
            state_q  <= CTRL_IDLE;
            done_q   <= 1'b1;
          end
        end
        default: state_q <= CTRL_IDLE;
      endcase
    end
  end

  // newest valid code wins; a request in the load cycle stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_code_q <= '0;
    end else if (req_ok) begin
      pend_q      <= 1'b1;
      pend_code_q <= rate_code_i;
    end else if (state_q == CTRL_RATE && load_o) begin
      pend_q <= 1'b0;
    end
  end

  assign busy_o = (state_q != CTRL_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int GAP_SCLK = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       rate_req_i,
  input  logic [7:0] rate_code_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       cs_n_o,
  output logic       busy_o,
  output logic       done_o
);
  logic              load, ready, word_done;
  logic [WORD_W-1:0] word;

  codec_cfg_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rate_req_i  (rate_req_i),
    .rate_code_i (rate_code_i),
    .ready_i     (ready),
    .word_done_i (word_done),
    .load_o      (load),
    .word_o      (word),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  codec_cfg_shifter #(
    .CLK_DIV  (CLK_DIV),
    .GAP_SCLK (GAP_SCLK)
  ) u_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .word_i      (word),
    .ready_o     (ready),
    .word_done_o (word_done),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .cs_n_o      (cs_n_o)
  );
endmodule

// File: rtl/codec_cfg_chk.sv
module codec_cfg_chk #(
  parameter int CLK_DIV  = 4,
  parameter int GAP_SCLK = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic mosi_o,
  input logic cs_n_o,
  input logic busy_o,
  input logic done_o
);
  localparam int FRAME   = 16 * CLK_DIV;
  localparam int GAP_CYC = GAP_SCLK * CLK_DIV;

  logic [31:0] low_cnt, high_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt  <= '0;
      high_cnt <= 32'(GAP_CYC);
    end else begin
      low_cnt  <= cs_n_o ? '0 : low_cnt + 1;
      if (!cs_n_o)                   high_cnt <= '0;
      else if (high_cnt < GAP_CYC)   high_cnt <= high_cnt + 1;
    end
  end

  a_r1_idle_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o);
  a_r4_quiet_outside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (!sclk_o && !mosi_o));
  a_r2_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));
  a_r4_frame_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_o) |-> (low_cnt == 32'(FRAME)));
  a_r4_min_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> (high_cnt >= 32'(GAP_CYC)));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_with_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && $rose(cs_n_o)));
  a_r8_done_busy_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind codec_cfg_seq codec_cfg_chk #(
  .CLK_DIV  (CLK_DIV),
  .GAP_SCLK (GAP_SCLK)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sclk_o (sclk_o),
  .mosi_o (mosi_o),
  .cs_n_o (cs_n_o),
  .busy_o (busy_o),
  .done_o (done_o)
);

// File: tb/codec_cfg_seq_bench.sv
`timescale 1ns/1ps
module codec_cfg_seq_bench;
  localparam int CLK_DIV  = 4;
  localparam int GAP_SCLK = 2;
  localparam int FRAME    = 16 * CLK_DIV;
  localparam int GAP_CYC  = GAP_SCLK * CLK_DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rate_req = 1'b0;
  logic [7:0] rate_code = '0;
  logic sclk, mosi, cs_n, busy, done;

  always #10 clk = ~clk;

  codec_cfg_seq #(.CLK_DIV(CLK_DIV), .GAP_SCLK(GAP_SCLK)) u_codec_cfg_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rate_req_i(rate_req),
    .rate_code_i(rate_code), .sclk_o(sclk), .mosi_o(mosi), .cs_n_o(cs_n),
    .busy_o(busy), .done_o(done));

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] words [0:63];
  int nwords = 0, done_cnt = 0;
  bit busy_seen = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_boot(input int i);
    case (i)
      0, 1: return 9'h017;
      2, 3: return 9'h0D8;
      4: return 9'h011;
      7: return 9'h043;
      8: return 9'h081;
      9: return 9'h001;
      default: return 9'h000;
    endcase
  endfunction

  function automatic logic [7:0] code_at(input int i);
    logic [7:0] t [0:6] = '{8'h06, 8'h2C, 8'h20, 8'h0C, 8'h11, 8'h00, 8'h0E};
    return t[i];
  endfunction

  function automatic bit code_known(input logic [7:0] c);
    for (int i = 0; i < 7; i++) if (code_at(i) == c) return 1'b1;
    return 1'b0;
  endfunction

  // pin monitor: frame shape, captured words, done pulses
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_busy = 1'b0;
  logic [15:0] shw;
  int bits, low_len, high_len;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n && prev_cs) begin
        bits = 0; shw = '0; low_len = 0;
        if (nwords > 0) check(high_len >= GAP_CYC, "R4 gap between words", high_len, GAP_CYC);
      end
      if (!cs_n) begin
        low_len++;
        if (sclk && !prev_sclk) begin shw = {shw[14:0], mosi}; bits++; end
      end else high_len++;
      if (cs_n && !prev_cs) begin
        check(bits == 16, "R2 clock edges per word", bits, 16);
        check(low_len == FRAME, "R4 chip-select low length", low_len, FRAME);
        if (nwords < 64) words[nwords] = shw;
        nwords++;
        high_len = 1;
      end
      if (done) begin
        done_cnt++;
        check(!busy && prev_busy && cs_n, "R8 done with busy fall", {busy, prev_busy, cs_n}, 3'b011);
      end
      if (busy) busy_seen = 1;
      prev_cs = cs_n; prev_sclk = sclk; prev_busy = busy;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic pulse_req(input logic [7:0] c);
    rate_code = c; rate_req = 1'b1;
    @(negedge clk);
    rate_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [7:0] c;
    int base;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({cs_n, sclk, mosi, busy, done} == 5'b10000, "R1 reset outputs", {cs_n, sclk, mosi, busy, done}, 5'b10000);
    repeat (40) @(negedge clk);
    check(nwords == 0 && !busy_seen, "R1 idle before start", nwords, 0);

    // boot with mid-sequence start and rate requests
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy, "R8 busy after start", busy, 1);
    while (nwords < 3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    check(busy, "R9 start while busy", busy, 1);
    pulse_req(8'h07);
    pulse_req(8'h2C);
    repeat (5) @(negedge clk);
    pulse_req(8'h0E);
    while (done_cnt < 1) @(negedge clk);
    check(nwords == 10, "R3 boot word count", nwords, 10);
    for (int i = 0; i < 10; i++)
      check(words[i] == {7'(i), exp_boot(i)}, $sformatf("R3 boot word %0d", i), words[i], {7'(i), exp_boot(i)});
    check(words[9][15:9] == 7'd9, "R3 activation last", words[9][15:9], 9);
    while (done_cnt < 2) @(negedge clk);
    check(nwords == 11, "R7 held request served once", nwords, 11);
    check(words[10] == {7'd8, 1'b0, 8'h0E}, "R7 newest code used", words[10], {7'd8, 1'b0, 8'h0E});
    repeat (400) @(negedge clk);
    check(nwords == 11 && !busy, "R9 no boot restart", nwords, 11);

    // every rate code
    for (int i = 0; i < 7; i++) begin
      base = nwords;
      pulse_req(code_at(i));
      repeat (200) @(negedge clk);
      check(nwords == base + 1, "R5 one word per rate request", nwords, base + 1);
      check(words[base] == {7'd8, 1'b0, code_at(i)}, "R5 rate word", words[base], {7'd8, 1'b0, code_at(i)});
    end

    // unknown code
    base = nwords; busy_seen = 0;
    pulse_req(8'hFF);
    repeat (200) @(negedge clk);
    check(nwords == base && !busy_seen, "R6 unknown code ignored", nwords, base);

    // random codes
    for (int k = 0; k < 24; k++) begin
      c = ($urandom % 2) ? code_at($urandom % 7) : 8'($urandom);
      base = nwords; busy_seen = 0;
      pulse_req(c);
      repeat (200) @(negedge clk);
      if (code_known(c)) begin
        check(nwords == base + 1, "R5 random valid code", nwords, base + 1);
        check(words[base] == {7'd8, 1'b0, c}, "R5 random rate word", words[base], {7'd8, 1'b0, c});
      end else begin
        check(nwords == base && !busy_seen, "R6 random unknown code", nwords, base);
      end
    end
    summary();
  end
endmodule